// File: doc/BRIEF.md
# Serial Port Control Register with Bit-Clock Divider

This block is the single control register of a synchronous serial port. It sits at one word offset inside a small peripheral address window and is reached over a plain register bus with an address, a write strobe, a read strobe and 16-bit data in each direction. The stored fields select how far the system clock is divided to make the serial bit clock, and they drive two device-select outputs for the attached serial devices.

The bit clock idles low and has a 50% duty cycle. A clock-enable input gates the divider counter. When the system clock runs at a reduced effective rate, the bit clock slows in the same proportion. If a write changes the divide setting, the counter restarts from zero, so the new ratio starts on a clean half-period. The two select outputs never assert together. If software requests both, select 0 wins. Reads return the stored fields with fixed padding in the unused bit positions.

Top module: `serial_ctl_reg`

## Requirements
- R1: After reset both select outputs and the bit clock are low, and a read of the register returns 16'hFFC0.
- R2: A write with the bus address equal to the register offset (word address 8'h12) stores write-data bits [5:4] as the divide field, bit 1 as select request 1 and bit 0 as select request 0. The new values appear on the outputs and in read data from the clock edge that samples the write strobe.
- R3: The bit clock toggles once every H enabled clocks, where H = 2^field. Field values 0, 1, 2 and 3 give a full period of 2, 4, 8 and 16 enabled clocks, with equal high and low times.
- R4: While select request 0 is clear, output sel1_o follows select request 1 and output sel0_o is low.
- R5: While select request 0 is set, sel0_o is high and sel1_o is low whatever select request 1 holds. The two outputs are never high together.
- R6: Read data bits [15:6] are always 1 and bits [3:2] are always 0, whatever was written to those positions.
- R7: While the clock-enable input is low, the divider counter and the bit clock hold their values. With the enable high on every other clock, each half-period lasts 2H system clocks.
- R8: A write that changes the divide field clears the counter without a toggle. The first toggle at the new ratio then comes H_new clocks after the write edge. A write that leaves the divide field unchanged does not disturb the running count.
- R9: A write to any other address leaves the stored fields and the outputs unchanged. Read data is zero when the read strobe is low or the address does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Enable that gates the divider counter |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| ser_clk_o | output | 1 | Divided serial bit clock |
| sel0_o | output | 1 | Device select 0 (priority) |
| sel1_o | output | 1 | Device select 1 |

## Verification
Read data is combinational, so the bench samples it one time step after it drives the read strobe, inside the same cycle. Stored fields and select outputs change at the edge that captures the write. The bench therefore checks them at the falling edge that follows that capture. Bit-clock timing is measured by counting falling-edge samples between transitions, which gives H and 2H for each ratio. After a ratio change the bench counts from the write edge and expects exactly H_new samples before the first toggle; after a same-value write the count continues from the last toggle instead.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int DATA_W   = 16;
    localparam int DIV_W    = 2;
    localparam int DIV_LSB  = 4;
    localparam int REQ0_BIT = 0;
    localparam int REQ1_BIT = 1;
    localparam int PAD0_LSB = 2;
    localparam int PAD0_W   = 2;
    localparam int PAD1_LSB = DIV_LSB + DIV_W;
    localparam int PAD1_W   = DATA_W - PAD1_LSB;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             req1;
        logic             req0;
    } ctl_t;

    function automatic logic [DATA_W-1:0] pack_read(input ctl_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[PAD1_LSB +: PAD1_W]  = '1;
        r[PAD0_LSB +: PAD0_W]  = '0;
        r[DIV_LSB +: DIV_W]    = c.div;
        r[REQ1_BIT]            = c.req1;
        r[REQ0_BIT]            = c.req0;
        return r;
    endfunction
endpackage

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl_o,
    output logic              div_chg_o,
    output logic [DATA_W-1:0] rdata
);
    ctl_t ctl_d, ctl_q;
    logic hit;
    logic wr_hit;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[PAD1_LSB +: PAD1_W], wdata[PAD0_LSB +: PAD0_W]};

    always_comb begin
        hit       = (addr == REG_OFFSET);
        wr_hit    = wr && hit;
        ctl_d     = ctl_q;
        div_chg_o = 1'b0;
        if (wr_hit) begin
            ctl_d.div  = wdata[DIV_LSB +: DIV_W];
            ctl_d.req1 = wdata[REQ1_BIT];
            ctl_d.req0 = wdata[REQ0_BIT];
            div_chg_o  = (wdata[DIV_LSB +: DIV_W] != ctl_q.div);
        end
        rdata = (rd && hit) ? pack_read(ctl_q) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

    p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (ctl_q.div == $past(wdata[DIV_LSB +: DIV_W]))
                && (ctl_q.req0 == $past(wdata[REQ0_BIT]))
                && (ctl_q.req1 == $past(wdata[REQ1_BIT])));

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctl_q));
endmodule

// File: rtl/sctl_clkdiv.sv
module sctl_clkdiv
    import sctl_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          restart,
    input  logic [DW-1:0] div,
    output logic          sclk_o
);
    localparam int CNT_W = (2 ** DW) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W:0]   half;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half    = (CNT_W+1)'(1) << div;
        half_m1 = CNT_W'(half - 1'b1);
        st_d    = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (ce) begin
            if (st_q.cnt >= half_m1) begin
                st_d.cnt  = '0;
                st_d.sclk = ~st_q.sclk;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= half_m1);

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !restart) |=> ($stable(st_q.sclk) && $stable(st_q.cnt)));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0) && $stable(st_q.sclk));
endmodule

// File: rtl/sctl_sel.sv
module sctl_sel (
    input  logic req0,
    input  logic req1,
    output logic sel0,
    output logic sel1
);
    always_comb begin
        sel0 = req0;
        sel1 = req1 && !req0;
    end
endmodule

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg
    import sctl_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              ser_clk_o,
    output logic              sel0_o,
    output logic              sel1_o
);
    ctl_t ctl;
    logic div_chg;

    sctl_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .ctl_o     (ctl),
        .div_chg_o (div_chg),
        .rdata     (bus_rdata)
    );

    sctl_clkdiv #(.DW(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (clk_en),
        .restart (div_chg),
        .div     (ctl.div),
        .sclk_o  (ser_clk_o)
    );

    sctl_sel u_sel (
        .req0 (ctl.req0),
        .req1 (ctl.req1),
        .sel0 (sel0_o),
        .sel1 (sel1_o)
    );

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel0_o && sel1_o));

    p_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != '0) |-> ((&bus_rdata[15:6]) && (bus_rdata[3:2] == 2'b00)));
endmodule

// File: tb/serial_ctl_reg_tb_top.sv
module serial_ctl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ser_clk_o, sel0_o, sel1_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit alt_ce = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_ctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ser_clk_o(ser_clk_o), .sel0_o(sel0_o), .sel1_o(sel1_o)
    );

    always @(negedge clk) if (alt_ce) clk_en <= ~clk_en;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic measure(output int hi, output int per);
        logic prev;
        int n;
        n = 0; prev = ser_clk_o;
        forever begin
            @(negedge clk); n++;
            if ((!prev && ser_clk_o) || n > 400) break;
            prev = ser_clk_o;
        end
        hi = 0;
        forever begin
            @(negedge clk); hi++;
            if (!ser_clk_o || hi > 400) break;
        end
        per = hi;
        forever begin
            @(negedge clk); per++;
            if (ser_clk_o || per > 800) break;
        end
    endtask

    task automatic edges_to_toggle(output int n);
        logic lvl;
        lvl = ser_clk_o; n = 0;
        forever begin
            @(negedge clk); n++;
            if (ser_clk_o != lvl || n > 400) break;
        end
    endtask

    initial begin
        logic [15:0] rd;
        int hi, per, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 sclk", ser_clk_o, 0);
        check("R1 sel0", sel0_o, 0);
        check("R1 sel1", sel1_o, 0);
        bus_read(8'h12, rd);
        check("R1 readback", rd, 16'hFFC0);
        // R9: read strobe low gives zero
        @(negedge clk); bus_addr = 8'h12; #1 check("R9 no strobe", bus_rdata, 0);

        clk_en = 1'b1;
        // R2 R4 R5 R6: sweep fields with junk in padding
        for (int dv = 0; dv < 4; dv++) begin
            for (int en = 0; en < 4; en++) begin
                bus_write(8'h12, 16'h5A0C | 16'(dv << 4) | 16'(en));
                check("R2 sel0", sel0_o, en & 1);
                check(((en & 1) != 0) ? "R5 sel1" : "R4 sel1", sel1_o, ((en >> 1) & 1) & ~(en & 1) & 1);
                bus_read(8'h12, rd);
                check("R6 readback", rd, 16'hFFC0 | (dv << 4) | en);
            end
            // R3: ratio and duty
            measure(hi, per);
            check("R3 high time", hi, 1 << dv);
            check("R3 period", per, 2 << dv);
        end

        // R7: enable on alternate clocks doubles the times
        bus_write(8'h12, 16'h0010);
        alt_ce = 1'b1;
        measure(hi, per);
        check("R7 high time", hi, 4);
        check("R7 period", per, 8);
        alt_ce = 1'b0;
        @(negedge clk); clk_en = 1'b0;
        begin
            logic lvl;
            lvl = ser_clk_o;
            repeat (20) @(negedge clk);
            check("R7 frozen", ser_clk_o, lvl);
        end
        clk_en = 1'b1;

        // R8: ratio change restarts the count
        bus_write(8'h12, 16'h0030);
        repeat (5) @(negedge clk);
        @(negedge clk);
        bus_addr = 8'h12; bus_wdata = 16'h0020; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        edges_to_toggle(n);
        check("R8 restart", n, 4);
        // R8: same-value write keeps count (toggle just seen, H=4)
        bus_addr = 8'h12; bus_wdata = 16'h0020; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        edges_to_toggle(n);
        check("R8 no restart", n, 3);

        // R9: other offsets ignored
        bus_write(8'h12, 16'h0001);
        bus_write(8'h13, 16'h0032);
        bus_write(8'h11, 16'h0002);
        check("R9 sel0 kept", sel0_o, 1);
        check("R9 sel1 kept", sel1_o, 0);
        bus_read(8'h12, rd);
        check("R9 stored", rd, 16'hFFC1);
        bus_read(8'h13, rd);
        check("R9 other read", rd, 0);
        measure(hi, per);
        check("R9 ratio kept", per, 2);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule